// File: doc/BRIEF.md
# Receive Byte Queue with Encoded Occupancy

This block holds the bytes that a serial receiver has finished assembling until software or a DMA engine reads them. A single-cycle strobe with a byte pushes it into a four-entry first-in first-out store. The oldest byte is always present on the read data port, and a read strobe removes it. The store is used only by the receive path and shares no storage with any transmit logic.

Besides the data, the block produces three status results. The first is a two-bit occupancy code that shows the number of held bytes minus one, saturating at zero. The second is a flag that shows the store is not empty. The third is an interrupt cause that is raised when the number of held bytes reaches a threshold. In standard mode the threshold is fixed at one byte. In advanced mode it is programmable from one to four bytes. When the receive enable is low, the store empties and incoming bytes are not accepted. A byte that arrives while the store is full is lost and sets a sticky overrun flag, which is cleared by a one on the clear input.

Top module: `rxq_top`

## Requirements
- R1: After reset, rd_data is 0, fill_code is 0, not_empty is 0, full_irq is 0 and overrun is 0.
- R2: Bytes come out in arrival order. A byte accepted at a clock edge, or the next oldest byte after a pop, appears on rd_data after that same edge.
- R3: fill_code reads 0 for 0 or 1 held bytes, and reads 1, 2 or 3 for 2, 3 or 4 held bytes.
- R4: not_empty is 1 whenever at least one byte is held, and it returns to 0 once the last byte has been read.
- R5: With adv_mode = 0, full_irq is 1 exactly when at least one byte is held.
- R6: With adv_mode = 1, full_irq is 1 exactly when the number of held bytes is at least irq_level + 1, so irq_level values 0 to 3 select thresholds 1 to 4.
- R7: While rx_en is 0, the store is emptied at each edge, byte_vld has no effect and full_irq is 0. rd_data keeps its last value.
- R8: A byte that arrives with rx_en = 1 while four bytes are held and no read is made is discarded, and overrun is set to 1. The held bytes and the count do not change.
- R9: overrun stays at 1 until a cycle with ovr_clr = 1 clears it. If a discard happens in the same cycle as the clear, the discard wins.
- R10: A push and a read in the same cycle while the store is not empty leave the count unchanged. This also holds when the store is full, and in that case no byte is discarded.
- R11: A read while the store is empty leaves rd_data and the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; 0 flushes the store |
| byte_vld | input | 1 | One-cycle strobe: byte_in holds a completed byte |
| byte_in | input | 8 | Received byte |
| rd_stb | input | 1 | Read strobe; pops the oldest byte |
| adv_mode | input | 1 | 0 = standard threshold of one, 1 = programmable threshold |
| irq_level | input | 2 | Advanced threshold minus one |
| ovr_clr | input | 1 | Writes one to clear the overrun flag |
| rd_data | output | 8 | Oldest held byte, or the last presented byte when empty |
| fill_code | output | 2 | Occupancy minus one, saturating at zero |
| not_empty | output | 1 | At least one byte held |
| full_irq | output | 1 | Interrupt cause: held bytes at or above the threshold |
| overrun | output | 1 | Sticky flag: a byte was discarded |

## Verification
Every stored effect takes exactly one edge. A push, pop, flush, discard or clear applied before an edge is visible on rd_data, fill_code, not_empty, full_irq and overrun right after that edge. The threshold inputs adv_mode and irq_level act on full_irq combinationally, with no edge needed. The bench changes inputs on the falling clock edge and samples all five outputs on the next falling edge. Each sample is compared against a queue model that the bench updates from the requirements for that same cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int unsigned RXQ_DATA_W = 8;
    localparam int unsigned RXQ_DEPTH  = 4;

    typedef enum logic {
        THR_FIXED_ONE = 1'b0,
        THR_PROGRAM   = 1'b1
    } rxq_mode_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 4,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic [CNT_W-1:0]  count,
    output logic              dropped
);
    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wp;
        logic [PTR_W-1:0]             rp;
        logic [CNT_W-1:0]             cnt;
        logic [DATA_W-1:0]            head;
    } store_t;

    store_t s_d, s_q;
    logic   do_pop, do_push;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        do_pop  = en && pop && (s_q.cnt != '0);
        do_push = en && push && ((s_q.cnt != CNT_W'(DEPTH)) || do_pop);
        dropped = en && push && !do_push;
        if (!en) begin
            s_d.wp  = '0;
            s_d.rp  = '0;
            s_d.cnt = '0;
        end else begin
            if (do_pop) begin
                s_d.rp = bump(s_q.rp);
            end
            if (do_push) begin
                s_d.mem[s_q.wp] = din;
                s_d.wp          = bump(s_q.wp);
            end
            s_d.cnt = s_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
        if (s_d.cnt != '0) begin
            s_d.head = s_d.mem[s_d.rp];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dout  = s_q.head;
    assign count = s_q.cnt;

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH));

    // R10
    push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && push && pop && s_q.cnt != '0) |=> $stable(count));

    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (count == '0));

    // R11
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pop && !push && s_q.cnt == '0) |=> ($stable(dout) && count == '0));
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] count,
    input  logic             dropped,
    input  logic             clr,
    input  rxq_pkg::rxq_mode_e mode,
    input  logic [PTR_W-1:0] level,
    output logic [PTR_W-1:0] code,
    output logic             busy,
    output logic             irq,
    output logic             ovr
);
    typedef struct packed {
        logic ovr;
    } flag_t;

    flag_t            f_d, f_q;
    logic [CNT_W-1:0] thr;

    always_comb begin
        f_d = f_q;
        if (dropped) begin
            f_d.ovr = 1'b1;
        end else if (clr) begin
            f_d.ovr = 1'b0;
        end
        thr  = (mode == rxq_pkg::THR_PROGRAM) ? CNT_W'(level) + 1'b1 : CNT_W'(1);
        code = (count == '0) ? '0 : PTR_W'(count - 1'b1);
        busy = (count != '0);
        irq  = en && (count >= thr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign ovr = f_q.ovr;

    // R9
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |=> ovr);

    // R4
    empty_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (code == '0 && !irq));

    // R5
    std_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == rxq_pkg::THR_FIXED_ONE && busy) |-> irq);
endmodule

// File: rtl/rxq_top.sv
module rxq_top #(
    parameter int unsigned DATA_W = rxq_pkg::RXQ_DATA_W,
    parameter int unsigned DEPTH  = rxq_pkg::RXQ_DEPTH,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              rd_stb,
    input  logic              adv_mode,
    input  logic [PTR_W-1:0]  irq_level,
    input  logic              ovr_clr,
    output logic [DATA_W-1:0] rd_data,
    output logic [PTR_W-1:0]  fill_code,
    output logic              not_empty,
    output logic              full_irq,
    output logic              overrun
);
    logic [CNT_W-1:0]   held;
    logic               lost;
    rxq_pkg::rxq_mode_e thr_mode;

    assign thr_mode = rxq_pkg::rxq_mode_e'(adv_mode);

    rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (rx_en),
        .push    (byte_vld),
        .din     (byte_in),
        .pop     (rd_stb),
        .dout    (rd_data),
        .count   (held),
        .dropped (lost)
    );

    rxq_flags #(.DEPTH(DEPTH)) i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (rx_en),
        .count   (held),
        .dropped (lost),
        .clr     (ovr_clr),
        .mode    (thr_mode),
        .level   (irq_level),
        .code    (fill_code),
        .busy    (not_empty),
        .irq     (full_irq),
        .ovr     (overrun)
    );
endmodule

// File: tb/test_rxq_top.sv
module test_rxq_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = '0;
    logic       rd_stb = 1'b0;
    logic       adv_mode = 1'b0;
    logic [1:0] irq_level = '0;
    logic       ovr_clr = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] fill_code;
    logic       not_empty, full_irq, overrun;

    int         vectors = 0;
    int         errors = 0;
    logic [7:0] mq[$];
    logic [7:0] m_last = '0;
    logic       m_ovr = 1'b0;

    always #5 clk = ~clk;

    rxq_top i_rxq_top (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .byte_vld(byte_vld),
        .byte_in(byte_in), .rd_stb(rd_stb), .adv_mode(adv_mode),
        .irq_level(irq_level), .ovr_clr(ovr_clr), .rd_data(rd_data),
        .fill_code(fill_code), .not_empty(not_empty), .full_irq(full_irq),
        .overrun(overrun)
    );

    task automatic cmp(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_state(string req);
        int n = mq.size();
        int thr = adv_mode ? int'(irq_level) + 1 : 1;
        cmp(req, "rd_data", rd_data, (n > 0) ? mq[0] : m_last);
        cmp(req, "fill_code", fill_code, (n > 1) ? n - 1 : 0);
        cmp(req, "not_empty", not_empty, n > 0);
        cmp(req, "full_irq", full_irq, rx_en && n >= thr);
        cmp(req, "overrun", overrun, m_ovr);
    endtask

    // one clock with the given strobes; inputs change on the falling edge
    task automatic step(input logic vld, input logic [7:0] b, input logic rd,
                        input logic clr);
        logic drop = 1'b0;
        byte_vld = vld; byte_in = b; rd_stb = rd; ovr_clr = clr;
        @(negedge clk);
        byte_vld = 1'b0; rd_stb = 1'b0; ovr_clr = 1'b0;
        if (!rx_en) begin
            mq.delete();
        end else begin
            if (rd && mq.size() > 0) void'(mq.pop_front());
            if (vld) begin
                if (mq.size() < 4) mq.push_back(b); else drop = 1'b1;
            end
        end
        if (drop) m_ovr = 1'b1; else if (clr) m_ovr = 1'b0;
        if (mq.size() > 0) m_last = mq[0];
    endtask

    task automatic drain();
        while (mq.size() > 0) step(1'b0, 8'h00, 1'b1, 1'b0);
    endtask

    task automatic t_reset();
        check_state("R1");
    endtask

    task automatic t_order();
        step(1'b1, 8'hA1, 1'b0, 1'b0); check_state("R2");
        step(1'b1, 8'hB2, 1'b0, 1'b0); check_state("R2");
        step(1'b1, 8'hC3, 1'b0, 1'b0); check_state("R2");
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 8'h00, 1'b1, 1'b0); check_state("R2");
        end
        cmp("R4", "not_empty after drain", not_empty, 0);
    endtask

    task automatic t_codes();
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 8'(8'h10 + i), 1'b0, 1'b0); check_state("R3");
        end
        cmp("R3", "fill_code at four", fill_code, 3);
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 8'h00, 1'b1, 1'b0); check_state("R4");
        end
    endtask

    task automatic t_overrun();
        for (int i = 0; i < 4; i++) step(1'b1, 8'(8'h40 + i), 1'b0, 1'b0);
        step(1'b1, 8'hEE, 1'b0, 1'b0); check_state("R8");
        cmp("R8", "head kept", rd_data, 8'h40);
        step(1'b0, 8'h00, 1'b0, 1'b0); check_state("R9");
        step(1'b1, 8'hEF, 1'b0, 1'b1); check_state("R9");
        cmp("R9", "set wins over clear", overrun, 1);
        step(1'b0, 8'h00, 1'b0, 1'b1); check_state("R9");
        cmp("R9", "cleared", overrun, 0);
        drain(); check_state("R8");
    endtask

    task automatic t_pushpop();
        step(1'b1, 8'h51, 1'b0, 1'b0);
        step(1'b1, 8'h52, 1'b0, 1'b0);
        step(1'b1, 8'h53, 1'b1, 1'b0); check_state("R10");
        cmp("R10", "count kept mid", fill_code, 1);
        step(1'b1, 8'h54, 1'b0, 1'b0);
        step(1'b1, 8'h55, 1'b0, 1'b0);
        step(1'b1, 8'h56, 1'b1, 1'b0); check_state("R10");
        cmp("R10", "no overrun at full", overrun, 0);
        drain(); check_state("R10");
    endtask

    task automatic t_empty_read();
        step(1'b1, 8'h77, 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        step(1'b0, 8'h00, 1'b1, 1'b0); check_state("R11");
        cmp("R11", "rd_data held", rd_data, 8'h77);
        step(1'b1, 8'h78, 1'b1, 1'b0); check_state("R11");
        drain();
    endtask

    task automatic t_std_irq();
        adv_mode = 1'b0; irq_level = 2'd3;
        #1 check_state("R5");
        step(1'b1, 8'h61, 1'b0, 1'b0); check_state("R5");
        cmp("R5", "irq at one byte", full_irq, 1);
        drain(); check_state("R5");
    endtask

    task automatic t_adv_irq();
        adv_mode = 1'b1;
        for (int lv = 0; lv < 4; lv++) begin
            irq_level = 2'(lv);
            for (int i = 0; i < 4; i++) begin
                step(1'b1, 8'(8'h80 + i), 1'b0, 1'b0);
                #1 check_state("R6");
            end
            drain();
        end
        adv_mode = 1'b0; irq_level = '0;
    endtask

    task automatic t_disable();
        step(1'b1, 8'h91, 1'b0, 1'b0);
        step(1'b1, 8'h92, 1'b0, 1'b0);
        rx_en = 1'b0;
        step(1'b0, 8'h00, 1'b0, 1'b0); check_state("R7");
        step(1'b1, 8'h93, 1'b0, 1'b0); check_state("R7");
        cmp("R7", "held byte kept", rd_data, 8'h91);
        rx_en = 1'b1;
        step(1'b0, 8'h00, 1'b0, 1'b0); check_state("R7");
    endtask

    initial begin
        fork
            begin
                repeat (2) @(negedge clk);
                #1 check_state("R1");
                rst_n = 1'b1; rx_en = 1'b1;
                @(negedge clk);
                t_reset();
                t_order();
                t_codes();
                t_overrun();
                t_pushpop();
                t_empty_read();
                t_std_irq();
                t_adv_irq();
                t_disable();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++; vectors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule